// File: doc/BRIEF.md
# Indirect Register Window Host Port

This block is the host-side slave port of a small network controller on a 16-bit ISA-style I/O bus. It claims a fixed sixteen-byte I/O window at base 0x300. Through that window it exposes three ports. A pointer port selects one word of a larger internal register space. A data port reads or writes the word the pointer selects. A frame port streams outgoing frame words into a small byte buffer. Each frame word is byte-swapped on entry, so host little-endian words land in network byte order.

The bus strobes are sampled in the block's clock domain. A read is recognised when the read strobe falls, and a write when the write strobe rises. The address-enable line acts as an active-low chip select. The block starts in 8-bit mode, in which each access moves one byte on the low data lane. It changes to 16-bit mode only after it has seen the high-byte-enable line change level. After reset a counter models a fixed initialisation time. Until that time ends, data-port reads of every register except the self-status word return zero. Software can poll the init-done flag instead of waiting a fixed time.

Top module: `regwin_bus`

## Requirements
- R1: The block claims an access only when address bits [9:4] equal those of the base 0x300 (addresses 0x300 to 0x30F). A read outside the window leaves dOut unchanged. A write outside the window changes no state.
- R2: While selN is high, reads leave dOut unchanged and writes change no state.
- R3: The pointer port is at offset 0xA and the data port at offset 0xC. Reading the pointer port returns the pointer. Bit 0 written to the pointer is forced to 0. The pointer changes only when the pointer port is written, and never when the data port is accessed.
- R4: After reset the pointer is 0x0000. Once initialisation is done, a 16-bit data read returns the identification word 0x630E: low lane 0x0E, high lane 0x63.
- R5: Pointer 0x0102 selects a fixed configuration word that reads 0x0003.
- R6: Pointer 0x0136 selects the self-status word. Bit 7 is init-done, which is set INIT_CYCLES clocks after reset. Bit 8 is busy, which reads 0 because no configuration memory is present. All other bits read 0. Until init-done is set, data reads of every other register return 0x0000.
- R7: Until hiEnN has changed level once after reset, the block is in 8-bit mode. In this mode an even offset moves the low byte of a port and an odd offset (0xB, 0xD) moves the high byte, using only dIn[7:0] and dOut[7:0], and dOut[15:8] reads 0. Frame-port writes are ignored in this mode. The change to 16-bit mode is permanent until reset.
- R8: A 16-bit write of word {H,L} to the frame port at offset 0x8 stores H at buffer byte k and L at byte k+1, where k is the frame write index. The index then advances by 2. Pointer 0x0A00+2j reads buffer bytes 2j and 2j+1 as {byte 2j+1, byte 2j}.
- R9: Pointer 0x0160 selects the frame length register. Writing it resets the frame write index to 0. The buffer stores only bytes whose index is below the length and below FRAME_BYTES, so the pad byte of an odd-length frame is discarded.
- R10: The read result appears on dOut at the first clock edge after the read strobe falls and holds until the next claimed read. A write takes effect at the first clock edge after the write strobe rises.
- R11: Pointers 0x0140+2i (i < SCR_WORDS) select read/write scratch words. These words are stored and returned without byte swapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 10 | I/O address lines |
| selN | input | 1 | Active-low address enable used as chip select |
| hiEnN | input | 1 | Active-low high-byte enable; its first change of level enables 16-bit mode |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| dIn | input | 16 | Write data from host |
| dOut | output | 16 | Registered read data to host |

## Verification
On every cycle the assertions check the following. The pointer and dOut stay put when no strobe targets them. The init-done flag and the 16-bit mode never fall back. The mode does not change while hiEnN is steady. A narrow read always clears the upper lane. A pre-init data read of any register but self status yields zero. Only the bench's scenarios can show the rest: the fixed word values, the byte-lane mapping in 8-bit mode, the decode and select rejection, the swapped frame storage, and the discarding of pad and overflow bytes. The bench checks these by sweeping scratch and frame words against patterns it computes itself.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PTR  = 2'd1,
    SRC_DATA = 2'd2
  } rdSrc_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic   ptrWr;
    logic   regWr;
    logic   frmWr;
    logic   loLane;
    logic   hiLane;
    logic   narrow;
    logic   rdLoad;
    rdSrc_e rdSrc;
    logic   initDone;
  } winCtl_t;
endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int BASE_ADDR   = 'h300,
  parameter int INIT_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selN,
  input  logic              hiEnN,
  input  logic              rdN,
  input  logic              wrN,
  output winCtl_t           ctl
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

  logic rdPrev, wrPrev, hiPrev, hiSeen, mode16, initDone;
  logic [CNT_W-1:0] initCnt;
  logic hit, ptrHit, datHit, frmHit, rdFall, wrRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev   <= 1'b1;
      wrPrev   <= 1'b1;
      hiPrev   <= 1'b1;
      hiSeen   <= 1'b0;
      mode16   <= 1'b0;
      initCnt  <= '0;
      initDone <= 1'b0;
    end else begin
      rdPrev <= rdN;
      wrPrev <= wrN;
      hiPrev <= hiEnN;
      hiSeen <= 1'b1;
      if (hiSeen && (hiEnN != hiPrev)) mode16 <= 1'b1;
      if (!initDone) begin
        initCnt <= initCnt + 1'b1;
        if (initCnt == CNT_LAST) initDone <= 1'b1;
      end
    end
  end

  always_comb begin
    hit    = !selN && (addr[ADDR_W-1:4] == BASE_V[ADDR_W-1:4]);
    ptrHit = hit && (addr[3:1] == 3'b101);
    datHit = hit && (addr[3:1] == 3'b110);
    frmHit = hit && (addr[3:1] == 3'b100);
    rdFall = rdPrev && !rdN;
    wrRise = !wrPrev && wrN;

    ctl.ptrWr    = wrRise && ptrHit;
    ctl.regWr    = wrRise && datHit;
    ctl.frmWr    = wrRise && frmHit && mode16;
    ctl.loLane   = mode16 || !addr[0];
    ctl.hiLane   = mode16 || addr[0];
    ctl.narrow   = !mode16;
    ctl.rdLoad   = rdFall && hit;
    ctl.rdSrc    = ptrHit ? SRC_PTR : (datHit ? SRC_DATA : SRC_NONE);
    ctl.initDone = initDone;
  end

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    mode16 |=> mode16); // R7
  AST_NARROW_WHILE_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!mode16 && hiSeen && (hiEnN == hiPrev)) |=> !mode16); // R7
  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone); // R6
endmodule

// File: rtl/regwin_dpath.sv
module regwin_dpath
  import regwin_pkg::*;
#(
  parameter int SCR_WORDS   = 8,
  parameter int FRAME_BYTES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  winCtl_t     ctl,
  input  logic [15:0] dIn,
  output logic [15:0] dOut
);
  localparam logic [15:0] ID_WORD  = 16'h630E;
  localparam logic [15:0] CFG_WORD = 16'h0003;
  localparam logic [15:0] ID_PTR   = 16'h0000;
  localparam logic [15:0] CFG_PTR  = 16'h0102;
  localparam logic [15:0] STAT_PTR = 16'h0136;
  localparam logic [15:0] SCR_BASE = 16'h0140;
  localparam logic [15:0] LEN_PTR  = 16'h0160;
  localparam logic [15:0] FRM_BASE = 16'h0A00;
  localparam int FRM_WORDS = FRAME_BYTES / 2;
  localparam logic BUSY_FLAG = 1'b0;

  logic [15:0] ptr, lenReg, frmIdx;
  logic [15:0] scr [SCR_WORDS];
  logic [7:0]  fb  [FRAME_BYTES];
  logic [15:0] wd, rawWord, gatedWord, srcWord;

  function automatic logic [15:0] mergeLanes(input logic [15:0] old, input logic [15:0] nw,
                                             input logic lo, input logic hi);
    return {hi ? nw[15:8] : old[15:8], lo ? nw[7:0] : old[7:0]};
  endfunction

  assign wd = ctl.narrow ? {dIn[7:0], dIn[7:0]} : dIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr    <= ID_PTR;
      lenReg <= '0;
      frmIdx <= '0;
      for (int i = 0; i < SCR_WORDS; i++) scr[i] <= '0;
      for (int b = 0; b < FRAME_BYTES; b++) fb[b] <= '0;
    end else begin
      if (ctl.ptrWr)
        ptr <= mergeLanes(ptr, wd, ctl.loLane, ctl.hiLane) & 16'hFFFE;
      if (ctl.regWr) begin
        if (ptr == LEN_PTR) begin
          lenReg <= mergeLanes(lenReg, wd, ctl.loLane, ctl.hiLane);
          frmIdx <= '0;
        end
        for (int i = 0; i < SCR_WORDS; i++)
          if (ptr == 16'(SCR_BASE + 2 * i))
            scr[i] <= mergeLanes(scr[i], wd, ctl.loLane, ctl.hiLane);
      end
      if (ctl.frmWr) begin
        for (int b = 0; b < FRAME_BYTES; b++) begin
          if ((16'(b) == frmIdx) && (frmIdx < lenReg)) fb[b] <= wd[15:8];
          if ((16'(b) == frmIdx + 16'd1) && ((frmIdx + 16'd1) < lenReg)) fb[b] <= wd[7:0];
        end
        if (frmIdx < 16'hFFFE) frmIdx <= frmIdx + 16'd2;
      end
    end
  end

  always_comb begin
    rawWord = '0;
    if (ptr == ID_PTR) rawWord = ID_WORD;
    if (ptr == CFG_PTR) rawWord = CFG_WORD;
    if (ptr == STAT_PTR) rawWord = {7'b0, BUSY_FLAG, ctl.initDone, 7'b0};
    if (ptr == LEN_PTR) rawWord = lenReg;
    for (int i = 0; i < SCR_WORDS; i++)
      if (ptr == 16'(SCR_BASE + 2 * i)) rawWord = scr[i];
    for (int k = 0; k < FRM_WORDS; k++)
      if (ptr == 16'(FRM_BASE + 2 * k)) rawWord = {fb[2*k+1], fb[2*k]};
    gatedWord = (!ctl.initDone && ptr != STAT_PTR) ? 16'h0000 : rawWord;
    case (ctl.rdSrc)
      SRC_PTR:  srcWord = ptr;
      SRC_DATA: srcWord = gatedWord;
      default:  srcWord = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) dOut <= '0;
    else if (ctl.rdLoad)
      dOut <= ctl.narrow ? {8'h00, (ctl.hiLane ? srcWord[15:8] : srcWord[7:0])} : srcWord;
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ptrWr |=> $stable(ptr)); // R3
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdLoad |=> $stable(dOut)); // R10
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdLoad && ctl.narrow) |=> (dOut[15:8] == 8'h00)); // R7
  AST_PRE_INIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdLoad && !ctl.initDone && ctl.rdSrc == SRC_DATA && ptr != STAT_PTR) |=> (dOut == 16'h0000)); // R6
endmodule

// File: rtl/regwin_bus.sv
module regwin_bus
  import regwin_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int BASE_ADDR   = 'h300,
  parameter int INIT_CYCLES = 40,
  parameter int SCR_WORDS   = 8,
  parameter int FRAME_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selN,
  input  logic              hiEnN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [15:0]       dIn,
  output logic [15:0]       dOut
);
  winCtl_t ctl;

  regwin_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .INIT_CYCLES(INIT_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .selN(selN), .hiEnN(hiEnN),
    .rdN(rdN), .wrN(wrN), .ctl(ctl)
  );

  regwin_dpath #(
    .SCR_WORDS(SCR_WORDS), .FRAME_BYTES(FRAME_BYTES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dIn(dIn), .dOut(dOut)
  );
endmodule

// File: tb/sim_regwin_bus.sv
module sim_regwin_bus;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] addr = '0;
  logic selN = 1'b1, hiEnN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [15:0] dIn = '0;
  logic [15:0] dOut;
  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  regwin_bus u0 (.clk(clk), .rstN(rstN), .addr(addr), .selN(selN), .hiEnN(hiEnN),
                 .rdN(rdN), .wrN(wrN), .dIn(dIn), .dOut(dOut));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wrBus(input logic [9:0] a, input logic [15:0] d, input logic sel = 1'b0);
    @(negedge clk); addr = a; dIn = d; selN = sel; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); selN = 1'b1;
  endtask

  task automatic rdBus(input logic [9:0] a, output logic [15:0] q, input logic sel = 1'b0);
    @(negedge clk); addr = a; selN = sel; rdN = 1'b0;
    @(negedge clk); q = dOut; rdN = 1'b1;
    @(negedge clk); selN = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    logic [15:0] q, prev;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    chk("R4 reset dOut", dOut, 16'h0000);
    // 8-bit mode, before init completes
    rdBus(10'h30C, q); chk("R6 pre-init id read zero", q, 16'h0000);
    wrBus(10'h30A, 16'h0037); wrBus(10'h30B, 16'h0001);
    rdBus(10'h30A, q); chk("R7 R3 ptr low byte bit0 cleared", q, 16'h0036);
    rdBus(10'h30B, q); chk("R7 ptr high byte", q, 16'h0001);
    rdBus(10'h30C, q); chk("R6 status before init", q, 16'h0000);
    repeat (50) @(negedge clk);
    rdBus(10'h30C, q); chk("R6 status init-done low byte", q, 16'h0080);
    rdBus(10'h30D, q); chk("R6 status busy clear", q, 16'h0000);
    wrBus(10'h30A, 16'h0000); wrBus(10'h30B, 16'h0000);
    rdBus(10'h30C, q); chk("R4 R7 id low lane", q, 16'h000E);
    rdBus(10'h30D, q); chk("R4 R7 id high lane", q, 16'h0063);
    wrBus(10'h30A, 16'h0040); wrBus(10'h30B, 16'h0001);
    wrBus(10'h30C, 16'h005A); wrBus(10'h30D, 16'h00C3);
    wrBus(10'h30A, 16'h0060);
    wrBus(10'h30C, 16'h0010);
    wrBus(10'h308, 16'hBEEF);
    // enable 16-bit mode
    @(negedge clk); hiEnN = 1'b0;
    repeat (3) @(negedge clk);
    rdBus(10'h30A, q); chk("R7 wide ptr read", q, 16'h0160);
    rdBus(10'h30C, q); chk("R9 length via byte write", q, 16'h0010);
    wrBus(10'h30A, 16'h0A00);
    rdBus(10'h30C, q); chk("R7 frame write ignored narrow", q, 16'h0000);
    wrBus(10'h30A, 16'h0140);
    rdBus(10'h30C, q); chk("R7 R11 byte-merged scratch", q, 16'hC35A);
    wrBus(10'h30A, 16'h0000);
    rdBus(10'h30C, q); chk("R4 id word", q, 16'h630E);
    wrBus(10'h30A, 16'h0102);
    rdBus(10'h30C, q); chk("R5 config word", q, 16'h0003);
    rdBus(10'h30C, q); chk("R3 R5 no auto-increment", q, 16'h0003);
    wrBus(10'h30A, 16'h0137);
    rdBus(10'h30A, q); chk("R3 ptr bit0 ignored", q, 16'h0136);
    rdBus(10'h30C, q); chk("R6 status wide", q, 16'h0080);
    // scratch sweep
    for (int i = 0; i < 8; i++) begin
      wrBus(10'h30A, 16'(16'h0140 + 2 * i));
      wrBus(10'h30C, 16'(16'hA55A ^ (i * 16'h1111)));
    end
    for (int i = 0; i < 8; i++) begin
      wrBus(10'h30A, 16'(16'h0140 + 2 * i));
      rdBus(10'h30C, q);
      chk($sformatf("R11 scratch %0d", i), q, 16'(16'hA55A ^ (i * 16'h1111)));
    end
    // select and decode rejection
    wrBus(10'h30A, 16'h0102);
    wrBus(10'h30A, 16'h0000, 1'b1);
    rdBus(10'h30A, q); chk("R2 deselected write ignored", q, 16'h0102);
    prev = q;
    wrBus(10'h30A, 16'h0000);
    rdBus(10'h30C, q, 1'b1); chk("R2 deselected read holds dOut", q, prev);
    wrBus(10'h30A, 16'h0102);
    wrBus(10'h31A, 16'h0000); wrBus(10'h20A, 16'h0000);
    rdBus(10'h30A, q); chk("R1 foreign writes ignored", q, 16'h0102);
    rdBus(10'h10C, q); chk("R1 foreign read holds dOut", q, 16'h0102);
    // read timing
    @(negedge clk); addr = 10'h30C; selN = 1'b0; rdN = 1'b0;
    #1; chk("R10 dOut before edge", dOut, 16'h0102);
    @(negedge clk); chk("R10 dOut after edge", dOut, 16'h0003);
    rdN = 1'b1;
    @(negedge clk); selN = 1'b1;
    // odd-length frame
    wrBus(10'h30A, 16'h0160); wrBus(10'h30C, 16'h0005);
    wrBus(10'h308, 16'h1122); wrBus(10'h308, 16'h3344); wrBus(10'h308, 16'h5566);
    wrBus(10'h30A, 16'h0A00); rdBus(10'h30C, q); chk("R8 frame word0 swapped", q, 16'h2211);
    wrBus(10'h30A, 16'h0A02); rdBus(10'h30C, q); chk("R8 frame word1 swapped", q, 16'h4433);
    wrBus(10'h30A, 16'h0A04); rdBus(10'h30C, q); chk("R9 pad byte discarded", q, 16'h0055);
    // full-buffer sweep
    wrBus(10'h30A, 16'h0160); wrBus(10'h30C, 16'h0010);
    for (int k = 0; k < 8; k++) wrBus(10'h308, 16'(16'h8421 ^ (k * 16'h1357)));
    wrBus(10'h308, 16'hFFFF);
    for (int k = 0; k < 8; k++) begin
      logic [15:0] w;
      w = 16'(16'h8421 ^ (k * 16'h1357));
      wrBus(10'h30A, 16'(16'h0A00 + 2 * k));
      rdBus(10'h30C, q);
      chk($sformatf("R8 R9 frame sweep %0d", k), q, {w[7:0], w[15:8]});
    end
    finish();
  end
endmodule